// File: doc/BRIEF.md
# Event Flag and Interrupt Pin Controller

This block collects three event strobes (a watchdog time-out, a clock alarm match and a power-fail indication) into a sticky flags register. A host uses a small register bus to read the flags and find the cause. Reading the flags clears them. Events that arrive in the same cycle as the read are kept.

A configuration register holds one enable bit per source and two bits that set the pin behaviour. The pin either holds its asserted level until the flags are read, or it fires a pulse of fixed length. The pin is also either active-high push-pull or active-low open-drain. The pin is modelled as a drive-enable and a drive-value pair. An external pad combines them into the physical pin.

The pin is driven by a three-state machine:
- `ST_IDLE`: no interrupt is active.
- `ST_PULSE`: a timed pulse is in progress, counted down from `PULSE_CYCLES`.
- `ST_HOLD`: a level interrupt is waiting for the flags read.

The transitions are as follows:
- `IDLE->PULSE`: an enabled event arrives with pulse mode set.
- `IDLE->HOLD`: an enabled event arrives with level mode set.
- `PULSE->PULSE`: an enabled event arrives and reloads the counter, or the counter is still running.
- `PULSE->IDLE`: the flags are read with no enabled event in the same cycle, or the count reaches zero.
- `HOLD->HOLD`: no flags read has occurred, or an enabled event arrives together with a read.
- `HOLD->IDLE`: the flags are read with no enabled event in the same cycle.

Top module: `intr_out_ctrl`

## Requirements
- R1: After reset the flags (address 0) and the configuration (address 1) both read 0x00, and both `pin_oe` and `pin_out` are 0.
- R2: An event strobe sets its flag on the next clock edge whether or not its source is enabled. The watchdog uses flags bit 0, the alarm bit 1 and power fail bit 2. Flags bits 7:3 always read 0.
- R3: An event whose enable bit is 0 never asserts the pin.
- R4: A read of address 0 returns the flags as they were before the clear. The read clears all flags on that clock edge. The next read of address 0 returns 0x00 unless a new event has arrived.
- R5: The configuration at address 1 is readable and writable with these bits:
  - bit 0: watchdog enable
  - bit 1: alarm enable
  - bit 2: power-fail enable
  - bit 3: polarity (1 = active-high push-pull, 0 = active-low open-drain)
  - bit 4: pulse mode (1 = pulse, 0 = level)
  - bits 7:5: read 0

  Writes to address 0 have no effect on either register.
- R6: In level mode an enabled event asserts the pin from the next edge onward. The pin stays asserted until the edge on which a flags read occurs, however long that takes.
- R7: In pulse mode an enabled event asserts the pin for exactly `PULSE_CYCLES` clock cycles, starting at the next edge.
- R8: A flags read during a pulse deasserts the pin on the edge of the read.
- R9: An enabled event during a pulse restarts it, so the pin stays asserted `PULSE_CYCLES` cycles after the last such event.
- R10: The pin output depends on the polarity bit:
  - Polarity 1: `pin_oe` is always 1 and `pin_out` equals the asserted state.
  - Polarity 0: `pin_out` is always 0 and `pin_oe` equals the asserted state.
- R11: An enabled event in the same cycle as a flags read keeps the pin asserted in level mode, and its flag reads as set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_wdt | input | 1 | Watchdog time-out strobe, one cycle |
| ev_alarm | input | 1 | Alarm match strobe, one cycle |
| ev_pfail | input | 1 | Power-fail strobe, one cycle |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register address: 0 = flags, 1 = configuration |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pin_oe | output | 1 | Pin drive enable |
| pin_out | output | 1 | Pin drive value |

## Verification
The assertions assume the following about the inputs:
- A read and a write never occur in the same cycle.
- The pulse-mode bit is not changed while an interrupt is active, because the check on level holding uses the live configuration bit.

The stimulus always writes the configuration first. It then reads the flags so the machine is idle, and only then applies events. Bus strobes are single-cycle and are never combined with each other.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int NUM_SRC  = 3;
    localparam int DATA_W   = 8;

    localparam int SRC_WDT   = 0;
    localparam int SRC_ALARM = 1;
    localparam int SRC_PFAIL = 2;

    localparam int CFG_HL = 3;
    localparam int CFG_PL = 4;
    localparam int CFG_USED = 5;

    localparam logic ADDR_FLAGS = 1'b0;
    localparam logic ADDR_CFG   = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } pin_state_e;
endpackage

// File: rtl/intr_cfg.sv
module intr_cfg
    import intr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_q
);
    localparam logic [DATA_W-1:0] CFG_MASK = DATA_W'((1 << CFG_USED) - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wdata & CFG_MASK;
        end
    end
endmodule

// File: rtl/intr_flags.sv
module intr_flags
    import intr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] events,
    input  logic               clr,
    output logic [NUM_SRC-1:0] flags_q
);
    logic [NUM_SRC-1:0] flags_n;

    always_comb begin
        flags_n = clr ? '0 : flags_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (events[i]) flags_n[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_n;
    end
endmodule

// File: rtl/intr_pin_fsm.sv
module intr_pin_fsm
    import intr_pkg::*;
#(
    parameter int PULSE_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr,
    input  logic pulse_mode,
    input  logic active_high,
    output logic active,
    output logic pin_oe,
    output logic pin_out
);
    localparam int CNT_W = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

    pin_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fire && pulse_mode) begin
                    state_n = ST_PULSE;
                    cnt_n   = CNT_LOAD;
                end else if (fire) begin
                    state_n = ST_HOLD;
                end
            end
            ST_PULSE: begin
                if (fire) begin
                    cnt_n = CNT_LOAD;
                end else if (clr || cnt_q == '0) begin
                    state_n = ST_IDLE;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (clr && !fire) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        active = (state_q != ST_IDLE);
        if (active_high) begin
            pin_oe  = 1'b1;
            pin_out = active;
        end else begin
            pin_oe  = active;
            pin_out = 1'b0;
        end
    end
endmodule

// File: rtl/intr_out_ctrl.sv
module intr_out_ctrl
    import intr_pkg::*;
#(
    parameter int PULSE_CYCLES = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_wdt,
    input  logic              ev_alarm,
    input  logic              ev_pfail,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pin_oe,
    output logic              pin_out
);
    logic [DATA_W-1:0]  cfg_q;
    logic [NUM_SRC-1:0] flags_q;
    logic [NUM_SRC-1:0] events;
    logic               flags_rd;
    logic               fire;
    logic               active;

    assign events   = {ev_pfail, ev_alarm, ev_wdt};
    assign flags_rd = bus_rd && (bus_addr == ADDR_FLAGS);
    assign fire     = |(events & cfg_q[NUM_SRC-1:0]);

    intr_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr && (bus_addr == ADDR_CFG)),
        .wdata (bus_wdata),
        .cfg_q (cfg_q)
    );

    intr_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .events  (events),
        .clr     (flags_rd),
        .flags_q (flags_q)
    );

    intr_pin_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .clr         (flags_rd),
        .pulse_mode  (cfg_q[CFG_PL]),
        .active_high (cfg_q[CFG_HL]),
        .active      (active),
        .pin_oe      (pin_oe),
        .pin_out     (pin_out)
    );

    always_comb begin
        if (bus_addr == ADDR_CFG) bus_rdata = cfg_q;
        else                      bus_rdata = {{(DATA_W-NUM_SRC){1'b0}}, flags_q};
    end
endmodule

// File: rtl/intr_out_ctrl_chk.sv
module intr_out_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_wdt,
    input logic       ev_alarm,
    input logic       ev_pfail,
    input logic       bus_rd,
    input logic       bus_addr,
    input logic [7:0] cfg_q,
    input logic [2:0] flags_q,
    input logic       active,
    input logic       pin_oe,
    input logic       pin_out
);
    logic en_hit;
    logic any_ev;
    logic rd_flags;
    assign en_hit   = |({ev_pfail, ev_alarm, ev_wdt} & cfg_q[2:0]);
    assign any_ev   = ev_wdt | ev_alarm | ev_pfail;
    assign rd_flags = bus_rd && !bus_addr;

    AST_WDT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wdt |=> flags_q[0]); // R2
    AST_PFAIL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pfail |=> flags_q[2]); // R2
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && !any_ev) |=> (flags_q == 3'b000)); // R4
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !en_hit) |=> !active); // R3
    AST_ENABLED_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        en_hit |=> active); // R9
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cfg_q[4] && !rd_flags) |=> active); // R6
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[3] |-> !pin_out); // R10
    AST_PP_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[3] |-> pin_oe); // R10
endmodule

bind intr_out_ctrl intr_out_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_wdt   (ev_wdt),
    .ev_alarm (ev_alarm),
    .ev_pfail (ev_pfail),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .cfg_q    (cfg_q),
    .flags_q  (flags_q),
    .active   (active),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out)
);

// File: tb/intr_out_ctrl_bench.sv
module intr_out_ctrl_bench;
    localparam int PC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_wdt = 0, ev_alarm = 0, ev_pfail = 0;
    logic       bus_rd = 0, bus_wr = 0, bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       pin_oe, pin_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    intr_out_ctrl #(.PULSE_CYCLES(PC)) u_intr_out_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_wdt(ev_wdt), .ev_alarm(ev_alarm),
        .ev_pfail(ev_pfail), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // {cfg[4:0], events{pfail,alarm,wdt}, exp_flags, exp_oe, exp_out}
    typedef logic [17:0] vec_t;
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        {5'b00001, 3'b001, 8'h01, 1'b1, 1'b0},
        {5'b00001, 3'b010, 8'h02, 1'b0, 1'b0},
        {5'b01010, 3'b010, 8'h02, 1'b1, 1'b1},
        {5'b01100, 3'b011, 8'h03, 1'b1, 1'b0},
        {5'b00111, 3'b111, 8'h07, 1'b1, 1'b0},
        {5'b01000, 3'b100, 8'h04, 1'b1, 1'b0},
        {5'b11100, 3'b100, 8'h04, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        cyc();
        bus_rd = 0;
    endtask

    task automatic ev(input logic [2:0] e);
        {ev_pfail, ev_alarm, ev_wdt} = e;
        cyc();
        {ev_pfail, ev_alarm, ev_wdt} = 3'b000;
    endtask

    initial begin
        logic [7:0] d;
        cyc();
        // R1 reset state
        chk("R1 oe", pin_oe, 0);
        chk("R1 out", pin_out, 0);
        rd(1'b0, d); chk("R1 flags", d, 8'h00);
        rd(1'b1, d); chk("R1 cfg", d, 8'h00);
        rst_n = 1;
        cyc();

        // vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            wr(1'b1, {3'b000, v[17:13]});
            rd(1'b0, d);
            ev(v[12:10]);
            chk("R3 R10 pin_oe", pin_oe, v[1]);
            chk("R3 R10 pin_out", pin_out, v[0]);
            rd(1'b0, d);
            chk("R2 flags", d, v[9:2]);
            chk("R10 idle oe", pin_oe, v[16]);
            chk("R10 idle out", pin_out, 0);
        end

        // R5 config register access
        wr(1'b1, 8'hFF); rd(1'b1, d); chk("R5 cfg mask", d, 8'h1F);
        wr(1'b0, 8'h00); rd(1'b1, d); chk("R5 addr0 write ignored", d, 8'h1F);
        rd(1'b0, d); chk("R5 flags untouched", d, 8'h00);
        wr(1'b1, 8'h0A); rd(1'b1, d); chk("R5 cfg value", d, 8'h0A);

        // R4 read returns pre-clear, then zero
        wr(1'b1, 8'h00);
        ev(3'b010);
        rd(1'b0, d); chk("R4 pre-clear", d, 8'h02);
        rd(1'b0, d); chk("R4 cleared", d, 8'h00);

        // R6 level hold beyond pulse length
        wr(1'b1, 8'h01);
        ev(3'b001);
        for (int k = 0; k < 3 * PC; k++) begin
            if (pin_oe !== 1'b1) chk("R6 hold", pin_oe, 1);
            cyc();
        end
        chk("R6 still held", pin_oe, 1);
        bus_rd = 1; bus_addr = 0;
        #1 chk("R6 held at read", pin_oe, 1);
        cyc(); bus_rd = 0;
        chk("R6 released", pin_oe, 0);

        // R7 pulse length
        wr(1'b1, 8'h19);
        ev(3'b001);
        for (int k = 0; k < PC; k++) begin
            if (pin_out !== 1'b1) chk("R7 pulse on", pin_out, 1);
            cyc();
        end
        chk("R7 pulse ended", pin_out, 0);
        rd(1'b0, d); chk("R7 flag kept", d, 8'h01);

        // R8 read ends pulse early
        ev(3'b001);
        cyc(); cyc();
        chk("R8 mid pulse", pin_out, 1);
        rd(1'b0, d);
        chk("R8 ended by read", pin_out, 0);

        // R9 restart
        ev(3'b001);
        cyc(); cyc(); cyc();
        ev(3'b001);
        for (int k = 0; k < PC; k++) begin
            if (pin_out !== 1'b1) chk("R9 restarted pulse", pin_out, 1);
            cyc();
        end
        chk("R9 end after restart", pin_out, 0);
        rd(1'b0, d);

        // R11 event with read, level open-drain
        wr(1'b1, 8'h01);
        ev(3'b001);
        bus_rd = 1; bus_addr = 0; ev_wdt = 1;
        #1 d = bus_rdata;
        cyc(); bus_rd = 0; ev_wdt = 0;
        chk("R11 read value", d, 8'h01);
        chk("R11 pin kept", pin_oe, 1);
        chk("R11 od value", pin_out, 0);
        rd(1'b0, d); chk("R11 flag survived", d, 8'h01);
        chk("R11 released", pin_oe, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule